// File: doc/BRIEF.md
# Write Burst Engine for a 16-bit Low-Power DDR Memory

This block sits on the controller side of a DDR memory interface and turns queued write requests into WRITE commands and their data bursts. A request carries a bank, a start column, an auto-precharge flag, the number of data pairs wanted, and one full burst of data with one mask bit per byte per element. When the engine accepts a request it puts the WRITE command on its command outputs in that same cycle. It then presents the data as one rising/falling pair per clock, with the matching mask pair and a strobe pattern pair. An external DDR output register serializes these pairs onto the pins.

The strobe is held low in the cycle of the command, which is the preamble. The first pair follows one clock after the command. After the last pair the strobe is held low for one more cycle, the postamble, and is then released. A new request may be accepted on the cycle in which the current burst outputs its last wanted pair. Its data then follows with no gap, which either chains the two bursts or truncates the first one. If a shortened burst is not cut off, the engine pads it to full length with fully masked elements, so the memory writes nothing for them.

Two hold-off flags tell the rest of the controller when a READ or a PRECHARGE may follow. Each flag reopens a programmable number of cycles after the last data cycle.

Top module: `ddr_wr_burst`

## Requirements
- R1: A WRITE is issued in the cycle where `req_valid` and `req_ready` are both high. In that cycle `cmd_wr` is high and `cmd_bank`, `cmd_col` and `cmd_ap` equal the request fields. In every other cycle `cmd_wr` is low.
- R2: In a cycle where a WRITE is issued and no data pair is being output, the engine drives the strobe low as a preamble: `dqs_oe`=1, `dqs_rise`=0, `dqs_fall`=0.
- R3: The first pair of a burst appears in the clock after its WRITE. Every data cycle has `dq_oe`=1, `dqs_oe`=1, `dqs_rise`=1 and `dqs_fall`=0.
- R4: Element e of a request is `req_data[e*DQ_W +: DQ_W]`. For a WRITE in cycle t, pair k is output in cycle t+1+k, with element 2k on `dq_rise` and element 2k+1 on `dq_fall`.
- R5: The mask of element e is `req_mask[e*BYTES +: BYTES]`. Bit j high means byte j (data bits 8j+7 to 8j) is not written. The mask is output unchanged on `dm_rise`/`dm_fall` together with its element.
- R6: `req_pairs` gives the number of wanted pairs, from 1 to BL/2. A value of 0, or one above BL/2, means BL/2. `req_ready` is low exactly in the cycles where the current burst still has a wanted pair after the one being output. A WRITE accepted N cycles after one with N wanted pairs therefore continues the data with no idle cycle.
- R7: A pair beyond the wanted count that is not cut off by a new WRITE is still output, with zero data and all mask bits high, up to the full burst length.
- R8: In the cycle after a data cycle, if no data pair is output, the engine holds a postamble: `dqs_oe`=1, strobe low, `dq_oe`=0. `dqs_oe` is low in any cycle that is neither a data cycle, nor a postamble, nor a WRITE cycle.
- R9: When `dq_oe` is low, the data outputs are zero, all mask bits are high and `dqs_rise` is low.
- R10: `rd_ok` is low in every data cycle, including padded ones, and for T_WTR cycles after the last one. It is high otherwise.
- R11: `pre_ok` is low in every data cycle, including padded ones, and for T_WR cycles after the last one. It is high otherwise.
- R12: While `rst_n` is low: `req_ready`=1, `cmd_wr`=0, `dq_oe`=0, `dqs_oe`=0, `rd_ok`=1 and `pre_ok`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_bank | input | BANK_W | Target bank |
| req_col | input | COL_W | Start column |
| req_ap | input | 1 | Close the row after the burst |
| req_pairs | input | $clog2(BL/2)+1 | Number of wanted data pairs |
| req_data | input | BL*DQ_W | Burst data, element 0 in the low bits |
| req_mask | input | BL*DQ_W/8 | Per-byte masks, high means skip |
| cmd_wr | output | 1 | WRITE command strobe |
| cmd_bank | output | BANK_W | Bank sent with the WRITE |
| cmd_col | output | COL_W | Column sent with the WRITE |
| cmd_ap | output | 1 | Auto-precharge flag sent with the WRITE |
| dq_rise | output | DQ_W | Data for the rising strobe half |
| dq_fall | output | DQ_W | Data for the falling strobe half |
| dm_rise | output | DQ_W/8 | Masks for the rising half |
| dm_fall | output | DQ_W/8 | Masks for the falling half |
| dq_oe | output | 1 | Drive enable for data and masks |
| dqs_rise | output | 1 | Strobe level in the first half of the cycle |
| dqs_fall | output | 1 | Strobe level in the second half of the cycle |
| dqs_oe | output | 1 | Drive enable for the strobe |
| rd_ok | output | 1 | A READ may be issued |
| pre_ok | output | 1 | A PRECHARGE may be issued |

## Verification
The hardest situation to reach is a second request that arrives exactly on, or just after, the last wanted pair of a shortened burst. This one cycle decides between a seamless chain, a truncation, a padded tail followed by a late WRITE, and a postamble that overlaps a new preamble. The stimulus sweeps every length code for two consecutive requests, each with every idle gap from zero to three cycles, so that each of these overlaps occurs. A second sweep walks all mask patterns across all length codes. Expected outputs come from a per-cycle timeline that the bench fills as it predicts each WRITE.

// File: rtl/wb_pkg.sv
package wb_pkg;

   // Strobe behaviour in one clock cycle
   typedef enum logic [1:0] {
      STB_OFF = 2'd0,   // strobe released
      STB_LOW = 2'd1,   // preamble or postamble: driven low
      STB_RUN = 2'd2    // data cycle: high then low
   } stb_phase_e;

   function automatic bit legal_burst(input int burst_len);
      return (burst_len == 2) || (burst_len == 4) || (burst_len == 8) || (burst_len == 16);
   endfunction

   function automatic int pair_count(input int burst_len);
      return burst_len / 2;
   endfunction

endpackage

// File: rtl/wb_seq.sv
module wb_seq #(
   parameter int NP    = 2,
   parameter int IDX_W = 1,
   parameter int LEN_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [LEN_W-1:0] req_pairs,
   output logic             req_ready,
   output logic             issue,
   output logic             act,
   output logic             wanted,
   output logic             post,
   output logic [IDX_W-1:0] pidx
);

   localparam logic [IDX_W-1:0] LAST = IDX_W'(NP - 1);
   localparam logic [LEN_W-1:0] FULL = LEN_W'(NP);

   logic             act_q, post_q;
   logic [IDX_W-1:0] pidx_q;
   logic [LEN_W-1:0] len_q, len_d;
   logic             at_last, more_wanted;

   always_comb begin
      len_d = req_pairs;
      if (req_pairs == '0 || req_pairs > FULL) len_d = FULL;
   end

   assign at_last     = (pidx_q == LAST);
   assign more_wanted = act_q && ((LEN_W'(pidx_q) + LEN_W'(1)) < len_q);
   assign req_ready   = !more_wanted;
   assign issue       = req_valid && req_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         post_q <= 1'b0;
         pidx_q <= '0;
         len_q  <= FULL;
      end else begin
         post_q <= act_q && at_last && !issue;
         if (issue) begin
            act_q  <= 1'b1;
            pidx_q <= '0;
            len_q  <= len_d;
         end else if (act_q) begin
            if (at_last) act_q <= 1'b0;
            else         pidx_q <= pidx_q + IDX_W'(1);
         end
      end
   end

   assign act    = act_q;
   assign post   = post_q;
   assign pidx   = pidx_q;
   assign wanted = act_q && (LEN_W'(pidx_q) < len_q);

   // R7: padded pairs only ever follow an earlier data cycle
   a_r7_pad_follows_data: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q && !wanted) |-> $past(act_q));

   // R6: a stall only happens while a burst is running
   a_r6_stall_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
      !req_ready |-> ($past(issue) || $past(act_q)));

endmodule

// File: rtl/wb_pair_sel.sv
module wb_pair_sel #(
   parameter int DQ_W  = 16,
   parameter int BYTES = 2,
   parameter int BL    = 4,
   parameter int NP    = 2,
   parameter int IDX_W = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [BL*DQ_W-1:0] ld_data,
   input  logic [BL*BYTES-1:0] ld_mask,
   input  logic               wanted,
   input  logic [IDX_W-1:0]   pidx,
   output logic [DQ_W-1:0]    dq_rise,
   output logic [DQ_W-1:0]    dq_fall,
   output logic [BYTES-1:0]   dm_rise,
   output logic [BYTES-1:0]   dm_fall
);

   logic [DQ_W-1:0]  dat_q [BL];
   logic [BYTES-1:0] msk_q [BL];
   logic [DQ_W-1:0]  rd_r, rd_f;
   logic [BYTES-1:0] rm_r, rm_f;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int e = 0; e < BL; e++) begin
            dat_q[e] <= '0;
            msk_q[e] <= '1;
         end
      end else if (load) begin
         for (int e = 0; e < BL; e++) begin
            dat_q[e] <= ld_data[e*DQ_W +: DQ_W];
            msk_q[e] <= ld_mask[e*BYTES +: BYTES];
         end
      end
   end

   generate
      if (NP == 1) begin : g_single
         assign rd_r = dat_q[0];
         assign rd_f = dat_q[1];
         assign rm_r = msk_q[0];
         assign rm_f = msk_q[1];
      end else begin : g_multi
         logic [IDX_W:0] e_rise, e_fall;
         assign e_rise = {pidx, 1'b0};
         assign e_fall = {pidx, 1'b1};
         assign rd_r = dat_q[e_rise];
         assign rd_f = dat_q[e_fall];
         assign rm_r = msk_q[e_rise];
         assign rm_f = msk_q[e_fall];
      end
   endgenerate

   always_comb begin
      dq_rise = '0;
      dq_fall = '0;
      dm_rise = '1;
      dm_fall = '1;
      if (wanted) begin
         dq_rise = rd_r;
         dq_fall = rd_f;
         dm_rise = rm_r;
         dm_fall = rm_f;
      end
   end

   // R9: a byte is never written when no wanted pair is selected
   a_r9_masked_when_unwanted: assert property (@(posedge clk) disable iff (!rst_n)
      !wanted |-> ((&dm_rise) && (&dm_fall)));

endmodule

// File: rtl/wb_holdoff.sv
module wb_holdoff #(
   parameter int DLY = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic busy,
   output logic ok
);

   generate
      if (DLY == 0) begin : g_none
         assign ok = !busy;
      end else begin : g_cnt
         localparam int CW = $clog2(DLY + 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              cnt_q <= '0;
            else if (busy)           cnt_q <= CW'(DLY);
            else if (cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
         end

         assign ok = !busy && (cnt_q == '0);

         // R10 / R11: the cycle right after data is still held off
         a_r10_tail_blocks: assert property (@(posedge clk) disable iff (!rst_n)
            $past(busy) |-> !ok);
      end
   endgenerate

   // R10 / R11: no permission while data is on the bus
   a_r10_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !ok);

endmodule

// File: rtl/ddr_wr_burst.sv
module ddr_wr_burst #(
   parameter int DQ_W   = 16,
   parameter int BL     = 4,
   parameter int BANK_W = 2,
   parameter int COL_W  = 10,
   parameter int T_WTR  = 2,
   parameter int T_WR   = 3,
   localparam int NP    = wb_pkg::pair_count(BL),
   localparam int BYTES = DQ_W / 8,
   localparam int LEN_W = $clog2(NP) + 1,
   localparam int IDX_W = (NP > 1) ? $clog2(NP) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic [BANK_W-1:0]   req_bank,
   input  logic [COL_W-1:0]    req_col,
   input  logic                req_ap,
   input  logic [LEN_W-1:0]    req_pairs,
   input  logic [BL*DQ_W-1:0]  req_data,
   input  logic [BL*BYTES-1:0] req_mask,
   output logic                cmd_wr,
   output logic [BANK_W-1:0]   cmd_bank,
   output logic [COL_W-1:0]    cmd_col,
   output logic                cmd_ap,
   output logic [DQ_W-1:0]     dq_rise,
   output logic [DQ_W-1:0]     dq_fall,
   output logic [BYTES-1:0]    dm_rise,
   output logic [BYTES-1:0]    dm_fall,
   output logic                dq_oe,
   output logic                dqs_rise,
   output logic                dqs_fall,
   output logic                dqs_oe,
   output logic                rd_ok,
   output logic                pre_ok
);

   import wb_pkg::*;

   // elaboration-time parameter checks
   generate
      if (!legal_burst(BL)) begin : g_bad_bl
         $error("burst length must be 2, 4, 8 or 16");
      end
      if (DQ_W % 8 != 0 || DQ_W < 8) begin : g_bad_dq
         $error("data width must be a whole number of bytes");
      end
      if (T_WTR < 0 || T_WR < 0) begin : g_bad_dly
         $error("hold-off delays must not be negative");
      end
   endgenerate

   logic             issue, act, wanted, post;
   logic [IDX_W-1:0] pidx;
   stb_phase_e       phase;
   logic [1:0]       ok_vec;

   wb_seq #(.NP(NP), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_pairs (req_pairs),
      .req_ready (req_ready),
      .issue     (issue),
      .act       (act),
      .wanted    (wanted),
      .post      (post),
      .pidx      (pidx)
   );

   wb_pair_sel #(.DQ_W(DQ_W), .BYTES(BYTES), .BL(BL), .NP(NP), .IDX_W(IDX_W)) u_sel (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (issue),
      .ld_data (req_data),
      .ld_mask (req_mask),
      .wanted  (wanted),
      .pidx    (pidx),
      .dq_rise (dq_rise),
      .dq_fall (dq_fall),
      .dm_rise (dm_rise),
      .dm_fall (dm_fall)
   );

   // one hold-off counter for READ (index 0) and one for PRECHARGE (index 1)
   generate
      for (genvar gi = 0; gi < 2; gi++) begin : g_hold
         wb_holdoff #(.DLY(gi == 0 ? T_WTR : T_WR)) u_hold (
            .clk   (clk),
            .rst_n (rst_n),
            .busy  (act),
            .ok    (ok_vec[gi])
         );
      end
   endgenerate

   assign rd_ok  = ok_vec[0];
   assign pre_ok = ok_vec[1];

   // command bus
   assign cmd_wr   = issue;
   assign cmd_bank = issue ? req_bank : '0;
   assign cmd_col  = issue ? req_col  : '0;
   assign cmd_ap   = issue && req_ap;

   // strobe pattern
   always_comb begin
      if (act)                phase = STB_RUN;
      else if (post || issue) phase = STB_LOW;
      else                    phase = STB_OFF;
   end

   assign dqs_oe   = (phase != STB_OFF);
   assign dqs_rise = (phase == STB_RUN);
   assign dqs_fall = 1'b0;
   assign dq_oe    = act;

   a_r1_cmd_from_request: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr |-> (req_valid && req_ready));

   a_r2_preamble_low: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && !dq_oe) |-> (dqs_oe && !dqs_rise && !dqs_fall));

   a_r3_first_pair_next: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr |=> (dq_oe && dqs_oe && dqs_rise && !dqs_fall));

   a_r4_first_element: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr |=> (dq_rise == $past(req_data[DQ_W-1:0])));

   a_r5_first_mask: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr |=> (dm_rise == $past(req_mask[BYTES-1:0])));

   a_r6_ready_only_in_data: assert property (@(posedge clk) disable iff (!rst_n)
      !req_ready |-> dq_oe);

   a_r8_postamble: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dq_oe) |-> (dqs_oe && !dqs_rise && !dqs_fall));

   a_r9_strobe_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !dq_oe |-> (!dqs_rise && dq_rise == '0 && dq_fall == '0));

endmodule

// File: tb/ddr_wr_burst_test.sv
module ddr_wr_burst_test;

   localparam int DQ_W = 16, BL = 4, NP = 2, BYTES = 2, LEN_W = 2;
   localparam int BANK_W = 2, COL_W = 10, T_WTR = 2, T_WR = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic                req_valid = 1'b0;
   logic                req_ready;
   logic [BANK_W-1:0]   req_bank = '0;
   logic [COL_W-1:0]    req_col = '0;
   logic                req_ap = 1'b0;
   logic [LEN_W-1:0]    req_pairs = '0;
   logic [BL*DQ_W-1:0]  req_data = '0;
   logic [BL*BYTES-1:0] req_mask = '0;
   logic                cmd_wr, cmd_ap;
   logic [BANK_W-1:0]   cmd_bank;
   logic [COL_W-1:0]    cmd_col;
   logic [DQ_W-1:0]     dq_rise, dq_fall;
   logic [BYTES-1:0]    dm_rise, dm_fall;
   logic                dq_oe, dqs_rise, dqs_fall, dqs_oe, rd_ok, pre_ok;

   ddr_wr_burst #(.DQ_W(DQ_W), .BL(BL), .BANK_W(BANK_W), .COL_W(COL_W),
                  .T_WTR(T_WTR), .T_WR(T_WR)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_bank(req_bank), .req_col(req_col), .req_ap(req_ap), .req_pairs(req_pairs),
      .req_data(req_data), .req_mask(req_mask), .cmd_wr(cmd_wr), .cmd_bank(cmd_bank),
      .cmd_col(cmd_col), .cmd_ap(cmd_ap), .dq_rise(dq_rise), .dq_fall(dq_fall),
      .dm_rise(dm_rise), .dm_fall(dm_fall), .dq_oe(dq_oe), .dqs_rise(dqs_rise),
      .dqs_fall(dqs_fall), .dqs_oe(dqs_oe), .rd_ok(rd_ok), .pre_ok(pre_ok));

   int n_chk = 0, n_bad = 0, cyc = 0;
   bit mon_on = 0, done_flag = 0;

   // expected timeline, one slot per cycle (ring of 64)
   bit               sv [64];
   bit               sh [64];
   int               skind [64];   // 1 wanted pair, 2 padded pair
   logic [DQ_W-1:0]  sdr [64], sdf [64];
   logic [BYTES-1:0] smr [64], smf [64];

   task automatic chk(input string req, input string what,
                      input logic [63:0] got, input logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got %h exp %h (cycle %0d)", req, what, got, exp, cyc);
      end
   endtask

   task automatic finish_up();
      done_flag = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   endtask

   function automatic int eff_pairs(input int p);
      return (p == 0 || p > NP) ? NP : p;
   endfunction

   function automatic logic [DQ_W-1:0] elem(input int seed, input int e);
      return DQ_W'(seed * 16'h1357 + e * 16'h0F1F + 16'h2468);
   endfunction

   always @(posedge clk) if (mon_on) cyc <= cyc + 1;

   // per-cycle comparison against the timeline
   always @(negedge clk) begin
      if (mon_on && !done_flag) begin
         int x;
         bit er, iss, v, vp, rw, pw;
         string mreq;
         x   = cyc;
         v   = sv[x & 63];
         vp  = sv[(x - 1) & 63];
         er  = !sh[x & 63];
         iss = req_valid && er;
         chk("R6", "req_ready", 64'(req_ready), 64'(er));
         chk("R1", "cmd_wr", 64'(cmd_wr), 64'(iss));
         if (iss) begin
            chk("R1", "cmd_bank", 64'(cmd_bank), 64'(req_bank));
            chk("R1", "cmd_col", 64'(cmd_col), 64'(req_col));
            chk("R1", "cmd_ap", 64'(cmd_ap), 64'(req_ap));
         end
         chk("R3", "dq_oe", 64'(dq_oe), 64'(v));
         chk("R4", "dq_rise", 64'(dq_rise), v ? 64'(sdr[x & 63]) : 64'd0);
         chk("R4", "dq_fall", 64'(dq_fall), v ? 64'(sdf[x & 63]) : 64'd0);
         mreq = !v ? "R9" : (skind[x & 63] == 1 ? "R5" : "R7");
         chk(mreq, "dm_rise", 64'(dm_rise), v ? 64'(smr[x & 63]) : 64'(2'b11));
         chk(mreq, "dm_fall", 64'(dm_fall), v ? 64'(smf[x & 63]) : 64'(2'b11));
         chk(v ? "R3" : (iss ? "R2" : "R8"), "dqs_oe", 64'(dqs_oe), 64'(v || vp || iss));
         chk(v ? "R3" : "R9", "dqs_rise", 64'(dqs_rise), 64'(v));
         chk("R3", "dqs_fall", 64'(dqs_fall), 64'd0);
         rw = 1; pw = 1;
         for (int i = 0; i <= T_WTR; i++) if (sv[(x - i) & 63]) rw = 0;
         for (int i = 0; i <= T_WR; i++)  if (sv[(x - i) & 63]) pw = 0;
         chk("R10", "rd_ok", 64'(rd_ok), 64'(rw));
         chk("R11", "pre_ok", 64'(pre_ok), 64'(pw));
         if (iss) begin
            int lp;
            lp = eff_pairs(int'(req_pairs));
            for (int k = 0; k < NP; k++) begin
               int s;
               s = (x + 1 + k) & 63;
               sv[s] = 1;
               sh[s] = (k < lp - 1);
               if (k < lp) begin
                  skind[s] = 1;
                  sdr[s] = req_data[(2*k)*DQ_W +: DQ_W];
                  sdf[s] = req_data[(2*k+1)*DQ_W +: DQ_W];
                  smr[s] = req_mask[(2*k)*BYTES +: BYTES];
                  smf[s] = req_mask[(2*k+1)*BYTES +: BYTES];
               end else begin
                  skind[s] = 2;
                  sdr[s] = '0; sdf[s] = '0;
                  smr[s] = '1; smf[s] = '1;
               end
            end
         end
         begin
            int c;
            c = (x + 44) & 63;
            sv[c] = 0; sh[c] = 0; skind[c] = 0;
         end
      end
   end

   task automatic send(input int seed, input int pairs, input logic [BL*BYTES-1:0] msk);
      req_valid = 1'b1;
      req_bank  = BANK_W'(seed);
      req_col   = COL_W'(seed * 8);
      req_ap    = seed[0];
      req_pairs = LEN_W'(pairs);
      for (int e = 0; e < BL; e++) req_data[e*DQ_W +: DQ_W] = elem(seed, e);
      req_mask  = msk;
      @(negedge clk); #1;
      while (!req_ready) begin
         @(negedge clk); #1;
      end
      @(posedge clk); #2;
      req_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #2;
      end
   endtask

   initial begin
      for (int i = 0; i < 64; i++) begin
         sv[i] = 0; sh[i] = 0; skind[i] = 0;
         sdr[i] = '0; sdf[i] = '0; smr[i] = '1; smf[i] = '1;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R12", "req_ready in reset", 64'(req_ready), 64'd1);
      chk("R12", "cmd_wr in reset", 64'(cmd_wr), 64'd0);
      chk("R12", "dq_oe in reset", 64'(dq_oe), 64'd0);
      chk("R12", "dqs_oe in reset", 64'(dqs_oe), 64'd0);
      chk("R12", "rd_ok in reset", 64'(rd_ok), 64'd1);
      chk("R12", "pre_ok in reset", 64'(pre_ok), 64'd1);
      @(posedge clk); #2;
      rst_n  = 1'b1;
      mon_on = 1;
      idle(2);
      // chaining, truncation, padding and gaps: every length code pair
      for (int la = 0; la < 4; la++)
         for (int lb = 0; lb < 4; lb++)
            for (int gap = 0; gap < 4; gap++) begin
               int sd;
               sd = la * 16 + lb * 4 + gap;
               send(sd, la, BL*BYTES'(sd * 5));
               idle(gap);
               send(sd + 64, lb, BL*BYTES'(sd * 11 + 3));
               idle(7);
            end
      // every mask pattern under every length code
      for (int m = 0; m < 256; m++) begin
         send(m + 200, m & 3, BL*BYTES'(m));
         idle(m % 3);
      end
      idle(8);
      finish_up();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done_flag) begin
         n_chk++;
         n_bad++;
         $display("FAIL R6 watchdog: got no completion exp completion");
         finish_up();
      end
   end

endmodule